// File: doc/BRIEF.md
# Dual Reconfigurable Lookup Table with RAM and Shift Modes

This block holds two 16-bit lookup tables, called F and G. Each table is read through its own 4-bit address. A per-table pair of configuration bits decides what the table is:

- **Logic mode:** fixed contents that act as a logic function.
- **RAM mode:** a distributed RAM that is written synchronously.
- **Shift mode:** a 16-stage shift register whose read address picks the tap.

All three modes share one storage array per table and one combinational read path.

A shared write strobe drives both tables. In RAM mode the tables can be joined into a 32x1 memory. An extra bank-select input then steers each write to only one table, and F takes its write data from G's data pin. The bank select also drives a 2:1 mux that returns the 32-entry read result. In shift mode, F can take G's last stage as its serial input, which cascades the two tables into a 32-stage register. Initial contents arrive on two 16-bit inputs and are loaded while reset is high.

Top module: `lut_pair_cell`

## Requirements
- R1: The read outputs `f_out`/`g_out` return, combinationally and in every mode, bit `addr` of the table. Address bit 0 is the least significant.
- R2: While `rst` is 1, each table loads its init word (`f_init`/`g_init`) at the rising edge. Reset wins over any write.
- R3: A table is in logic mode when both its RAM bit and its shift bit are 0. In logic mode the table never changes on `we`.
- R4: In RAM mode, a rising edge with `we`=1 stores the table's write data at the table's current address. Other entries are left alone.
- R5: With `bank_steer_en`=1 in RAM mode, `bank_sel`=1 writes only F and `bank_sel`=0 writes only G. With `bank_steer_en`=0, both RAM tables are written and `bank_sel` has no effect on writing.
- R6: F's write data is `f_data` when `f_din_alt`=0. When `f_din_alt`=1, F takes `g_data` in RAM mode and G's bit 15 in shift mode. G's write data is always `g_data`.
- R7: In shift mode, each rising edge with `we`=1 moves bit i to bit i+1 and loads the write data into bit 0. `f_tap`/`g_tap` show bit 15.
- R8: `wide_out` equals `f_out` when `bank_sel`=1 and `g_out` when `bank_sel`=0. This gives F addresses 16–31 and G addresses 0–15 of a 32x1 RAM.
- R9: When both the RAM bit and the shift bit are set for a table, the table behaves as a shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and shift clock |
| rst | input | 1 | Synchronous active-high reset, loads init words |
| f_ram | input | 1 | F table RAM mode request |
| f_shift | input | 1 | F table shift mode request |
| g_ram | input | 1 | G table RAM mode request |
| g_shift | input | 1 | G table shift mode request |
| bank_steer_en | input | 1 | Use bank_sel to steer RAM writes to one table |
| f_din_alt | input | 1 | F write data from G side instead of f_data |
| f_init | input | 16 | F contents loaded on reset |
| g_init | input | 16 | G contents loaded on reset |
| f_addr | input | 4 | F read/write address |
| g_addr | input | 4 | G read/write address |
| bank_sel | input | 1 | Fifth address bit: write steering and wide mux select |
| we | input | 1 | Write / shift enable |
| f_data | input | 1 | F own data input |
| g_data | input | 1 | G data input |
| f_out | output | 1 | F read bit |
| g_out | output | 1 | G read bit |
| f_tap | output | 1 | F bit 15 |
| g_tap | output | 1 | G bit 15 |
| wide_out | output | 1 | 32x1 read result |

## Verification
Two situations can fall in one cycle. The first is that a shift and a cascade transfer happen on the same edge: G shifts out its bit 15 while F loads that same bit. The bench places a single 1 in G and clocks it 17 times. It expects the 1 to have left `g_tap` and to appear at F bit 0 on the 17th edge. The second is that reset and a RAM write request fall together. The bench holds `we` high during reset and expects the init value, not the written data.

// File: rtl/lut_pair_pkg.sv
package lut_pair_pkg;

    localparam int unsigned LUT_ADDR_W = 4;
    localparam int unsigned LUT_COUNT  = 2;
    localparam int unsigned TBL_G      = 0;
    localparam int unsigned TBL_F      = 1;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'd0,
        MODE_RAM   = 2'd1,
        MODE_SHIFT = 2'd2
    } tbl_mode_e;

    typedef struct packed {
        logic en;
        logic data;
    } tbl_wr_t;

    // Shift request outranks RAM request
    function automatic tbl_mode_e pick_mode(input logic ram_req, input logic shift_req);
        if (shift_req) return MODE_SHIFT;
        if (ram_req)   return MODE_RAM;
        return MODE_LOGIC;
    endfunction

endpackage

// File: rtl/lut_table.sv
module lut_table
    import lut_pair_pkg::*;
#(
    parameter int unsigned ADDR_W = LUT_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  tbl_mode_e                  mode,
    input  logic [(1<<ADDR_W)-1:0]     init_word,
    input  tbl_wr_t                    wr,
    input  logic [ADDR_W-1:0]          addr,
    output logic                       rd,
    output logic                       tap
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] store;

    always_ff @(posedge clk) begin
        if (rst) begin
            store <= init_word;
        end else if (wr.en) begin
            unique case (mode)
                MODE_SHIFT: store <= {store[DEPTH-2:0], wr.data};
                MODE_RAM:   store[addr] <= wr.data;
                default:    store <= store;
            endcase
        end
    end

    assign rd  = store[addr];
    assign tap = store[DEPTH-1];

endmodule

// File: rtl/lut_wr_ctl.sv
module lut_wr_ctl
    import lut_pair_pkg::*;
(
    input  tbl_mode_e f_mode,
    input  tbl_mode_e g_mode,
    input  logic      steer_en,
    input  logic      bank_sel,
    input  logic      we,
    input  logic      f_din_alt,
    input  logic      f_data,
    input  logic      g_data,
    input  logic      g_tap,
    output tbl_wr_t   wr_f,
    output tbl_wr_t   wr_g
);
    logic f_bank_ok;
    logic g_bank_ok;
    logic f_alt_bit;

    always_comb begin
        f_bank_ok = !steer_en || bank_sel;
        g_bank_ok = !steer_en || !bank_sel;
        f_alt_bit = (f_mode == MODE_SHIFT) ? g_tap : g_data;

        wr_f.data = f_din_alt ? f_alt_bit : f_data;
        wr_f.en   = we && ((f_mode == MODE_SHIFT) ||
                           ((f_mode == MODE_RAM) && f_bank_ok));

        wr_g.data = g_data;
        wr_g.en   = we && ((g_mode == MODE_SHIFT) ||
                           ((g_mode == MODE_RAM) && g_bank_ok));
    end

endmodule

// File: rtl/lut_pair_cell.sv
module lut_pair_cell
    import lut_pair_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        f_ram,
    input  logic        f_shift,
    input  logic        g_ram,
    input  logic        g_shift,
    input  logic        bank_steer_en,
    input  logic        f_din_alt,
    input  logic [15:0] f_init,
    input  logic [15:0] g_init,
    input  logic [3:0]  f_addr,
    input  logic [3:0]  g_addr,
    input  logic        bank_sel,
    input  logic        we,
    input  logic        f_data,
    input  logic        g_data,
    output logic        f_out,
    output logic        g_out,
    output logic        f_tap,
    output logic        g_tap,
    output logic        wide_out
);
    localparam int unsigned DEPTH = 1 << LUT_ADDR_W;

    tbl_mode_e              mode_a [LUT_COUNT];
    logic [DEPTH-1:0]       init_a [LUT_COUNT];
    logic [LUT_ADDR_W-1:0]  addr_a [LUT_COUNT];
    tbl_wr_t                wr_a   [LUT_COUNT];
    logic                   rd_a   [LUT_COUNT];
    logic                   tap_a  [LUT_COUNT];
    tbl_wr_t                wr_f;
    tbl_wr_t                wr_g;
    logic                   f_wen_i;
    logic                   f_wdat_i;

    assign mode_a[TBL_F] = pick_mode(f_ram, f_shift);
    assign mode_a[TBL_G] = pick_mode(g_ram, g_shift);
    assign init_a[TBL_F] = f_init;
    assign init_a[TBL_G] = g_init;
    assign addr_a[TBL_F] = f_addr;
    assign addr_a[TBL_G] = g_addr;
    assign wr_a[TBL_F]   = wr_f;
    assign wr_a[TBL_G]   = wr_g;

    lut_wr_ctl u_ctl (
        .f_mode    (mode_a[TBL_F]),
        .g_mode    (mode_a[TBL_G]),
        .steer_en  (bank_steer_en),
        .bank_sel  (bank_sel),
        .we        (we),
        .f_din_alt (f_din_alt),
        .f_data    (f_data),
        .g_data    (g_data),
        .g_tap     (tap_a[TBL_G]),
        .wr_f      (wr_f),
        .wr_g      (wr_g)
    );

    for (genvar t = 0; t < LUT_COUNT; t++) begin : g_tbl
        lut_table #(.ADDR_W(LUT_ADDR_W)) u_tbl (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode_a[t]),
            .init_word (init_a[t]),
            .wr        (wr_a[t]),
            .addr      (addr_a[t]),
            .rd        (rd_a[t]),
            .tap       (tap_a[t])
        );
    end

    assign f_wen_i  = wr_f.en;
    assign f_wdat_i = wr_f.data;

    assign f_out    = rd_a[TBL_F];
    assign g_out    = rd_a[TBL_G];
    assign f_tap    = tap_a[TBL_F];
    assign g_tap    = tap_a[TBL_G];
    assign wide_out = bank_sel ? rd_a[TBL_F] : rd_a[TBL_G];

endmodule

// File: rtl/lut_pair_cell_chk.sv
module lut_pair_cell_chk (
    input logic        clk,
    input logic        rst,
    input logic        f_ram,
    input logic        f_shift,
    input logic        g_ram,
    input logic        g_shift,
    input logic        bank_steer_en,
    input logic        bank_sel,
    input logic        we,
    input logic [15:0] f_init,
    input logic [3:0]  f_addr,
    input logic [3:0]  g_addr,
    input logic        g_data,
    input logic        f_out,
    input logic        g_out,
    input logic        f_wdat_i
);
    // R2
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && $stable(f_init)) |-> (f_out == f_init[f_addr]));

    // R3
    logic_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!f_ram && !f_shift) && $stable(f_addr)) |-> $stable(f_out));

    // R4
    ram_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(f_ram && !f_shift && we && (!bank_steer_en || bank_sel))
         && $stable(f_addr)) |-> (f_out == $past(f_wdat_i)));

    // R5
    steer_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(g_ram && !g_shift && we && bank_steer_en && bank_sel)
         && $stable(g_addr)) |-> $stable(g_out));

    // R7
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(g_shift && we) && (g_addr == 4'd0)) |-> (g_out == $past(g_data)));

endmodule

bind lut_pair_cell lut_pair_cell_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .f_ram         (f_ram),
    .f_shift       (f_shift),
    .g_ram         (g_ram),
    .g_shift       (g_shift),
    .bank_steer_en (bank_steer_en),
    .bank_sel      (bank_sel),
    .we            (we),
    .f_init        (f_init),
    .f_addr        (f_addr),
    .g_addr        (g_addr),
    .g_data        (g_data),
    .f_out         (f_out),
    .g_out         (g_out),
    .f_wdat_i      (f_wdat_i)
);

// File: tb/lut_pair_cell_test.sv
`timescale 1ns/1ps
module lut_pair_cell_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        f_ram = 1'b0, f_shift = 1'b0, g_ram = 1'b0, g_shift = 1'b0;
    logic        bank_steer_en = 1'b0, f_din_alt = 1'b0;
    logic [15:0] f_init = 16'hA5C3, g_init = 16'h0F0F;
    logic [3:0]  f_addr = 4'd0, g_addr = 4'd0;
    logic        bank_sel = 1'b0, we = 1'b0, f_data = 1'b0, g_data = 1'b0;
    logic        f_out, g_out, f_tap, g_tap, wide_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lut_pair_cell uut (
        .clk(clk), .rst(rst),
        .f_ram(f_ram), .f_shift(f_shift), .g_ram(g_ram), .g_shift(g_shift),
        .bank_steer_en(bank_steer_en), .f_din_alt(f_din_alt),
        .f_init(f_init), .g_init(g_init),
        .f_addr(f_addr), .g_addr(g_addr), .bank_sel(bank_sel), .we(we),
        .f_data(f_data), .g_data(g_data),
        .f_out(f_out), .g_out(g_out), .f_tap(f_tap), .g_tap(g_tap),
        .wide_out(wide_out)
    );

    // 32x1 RAM vectors: {write, addr[4:0], data, expected wide_out after op}
    localparam int NVEC = 11;
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'hCF, 8'h8C, 8'h4D, 8'h0C, 8'h7D, 8'h01,
        8'h10, 8'h93, 8'h50, 8'hE8, 8'h29
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] fi, input logic [15:0] gi);
        we = 1'b0;
        f_init = fi;
        g_init = gi;
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(16'hA5C3, 16'h0F0F);

        // R2 reset state, R1 bit order (g addr 3 -> bit3=1; reversed would give bit12=0)
        f_addr = 4'd5; g_addr = 4'd3;
        #1;
        check("R2 reset f", f_out, 1'b0);
        check("R1 g addr order", g_out, 1'b1);
        check("R2 tap f", f_tap, 1'b1);

        // R3 logic mode ignores we
        f_addr = 4'd5; g_addr = 4'd4; f_data = 1'b1; g_data = 1'b1; we = 1'b1;
        step();
        we = 1'b0;
        check("R3 f hold", f_out, 1'b0);
        check("R3 g hold", g_out, 1'b0);

        // R5 both written when steering off, bank_sel ignored; R4
        f_ram = 1'b1; g_ram = 1'b1; bank_steer_en = 1'b0; f_din_alt = 1'b0;
        bank_sel = 1'b0; f_addr = 4'd5; g_addr = 4'd5; f_data = 1'b1; g_data = 1'b1;
        we = 1'b1;
        step();
        we = 1'b0;
        check("R5 f written unsteered", f_out, 1'b1);
        check("R4 g written", g_out, 1'b1);
        f_addr = 4'd4;
        #1;
        check("R4 neighbour untouched", f_out, 1'b0);

        // R2 reset beats write
        f_addr = 4'd5; f_data = 1'b1; we = 1'b1; rst = 1'b1;
        step();
        check("R2 reset over write", f_out, 1'b0);
        rst = 1'b0; we = 1'b0;

        // 32x1 RAM vector walk: R5 R6 R8
        do_reset(16'hA5C3, 16'h0F0F);
        f_ram = 1'b1; g_ram = 1'b1; bank_steer_en = 1'b1; f_din_alt = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            f_addr   = VEC[i][5:2];
            g_addr   = VEC[i][5:2];
            bank_sel = VEC[i][6];
            g_data   = VEC[i][1];
            f_data   = ~VEC[i][1];
            we       = VEC[i][7];
            step();
            we = 1'b0;
            check($sformatf("R8 R5 R6 vec%0d", i), wide_out, VEC[i][0]);
        end

        // R7 shift, R6 cascade, R1 variable tap
        do_reset(16'h0000, 16'h0000);
        f_ram = 1'b0; g_ram = 1'b0; f_shift = 1'b1; g_shift = 1'b1;
        f_din_alt = 1'b1; bank_steer_en = 1'b0; f_addr = 4'd0; g_addr = 4'd4;
        f_data = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            g_data = (k == 1);
            we = 1'b1;
            step();
            we = 1'b0;
            if (k == 5)  check("R7 tap at addr4", g_out, 1'b1);
            if (k == 16) begin
                check("R7 g bit15", g_tap, 1'b1);
                check("R6 f not yet", f_out, 1'b0);
            end
            if (k == 17) begin
                check("R6 cascade into f", f_out, 1'b1);
                check("R7 g bit15 left", g_tap, 1'b0);
            end
        end

        // R9 shift has priority over RAM
        f_shift = 1'b0; g_shift = 1'b0;
        do_reset(16'h0001, 16'h0000);
        f_ram = 1'b1; f_shift = 1'b1; f_din_alt = 1'b0; f_data = 1'b0; f_addr = 4'd1;
        we = 1'b1;
        step();
        we = 1'b0;
        check("R9 shifted into bit1", f_out, 1'b1);
        f_addr = 4'd0;
        #1;
        check("R9 bit0 loaded", f_out, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule